// File: doc/BRIEF.md
# Latched Serial Angle Readout Port

This block is the read side of a three-wire slave port that hands a host the absolute shaft angle as a 12-bit binary word. When the host pulls its active-low select line down, the port freezes a copy of the live angle counter. It then returns that copy one bit at a time, most significant bit first. Each falling edge of the host's serial clock moves the port on by one bit.

While the select line is high the port drives nothing, so several ports can share one data wire. The enable output drives the pad's tri-state control. Both host lines are asynchronous to the system clock. Each passes through a synchronizer and an edge detector before it has any effect. The system clock must run at least eight times faster than the serial clock.

The host may stop a read early by raising select. That gives a coarser angle. If the host keeps clocking after the last significant bit, it receives zeros.

Top module: `angle_readout_port`

## Requirements
- R1: While the port is idle, `sdo_en` is 0 and `sdo` is 0.
- R2: A falling edge on `cs_n` raises `sdo_en` and captures `angle_in`. This happens on the third rising clock edge after the first edge that samples `cs_n` low. From that cycle `sdo` shows bit 11 (the MSB) of the captured angle.
- R3: Each falling edge of `sclk` while selected moves the output on by one bit, MSB toward LSB. The bit changes on the third clock edge after `sclk` is first sampled low. Twelve falling edges deliver the whole word.
- R4: Falling edges of `sclk` after the twelfth, while `cs_n` stays low, return 0 on `sdo`.
- R5: A rising edge on `cs_n` drops `sdo_en` and clears the output, after the same three-edge latency. This holds whether or not all 12 bits have been read, so a read of N bits returns the top N bits of the angle.
- R6: Changes on `angle_in` while `cs_n` is low leave the word being shifted out unchanged.
- R7: Every new select cycle captures a fresh snapshot of `angle_in`.
- R8: Synchronous reset puts the port in idle with `sdo_en` at 0.
- R9: Falling edges of `sclk` while `cs_n` is high have no effect. The next read still begins at the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| angle_in | input | 12 | Live absolute angle from the tracking counter |
| cs_n | input | 1 | Select from the host, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | Output enable for the tri-state data pad |

## Verification
The bench builds the port with its default 12-bit word and two-stage synchronizers. The serial clock runs at one twelfth of the system clock, so the eight-to-one ratio is met with margin. The bench compares every cycle against a behavioural model, which exposes the exact three-edge latency of both select edges. Reads of 16, 12 and 5 bits reach the zero fill after the twelfth edge and the early stop. Mid-read angle changes, idle clocking and all-ones, all-zeros and single-MSB angles cover the word boundaries.

// File: rtl/angle_port_pkg.sv
package angle_port_pkg;

    localparam int DEF_ANGLE_W    = 12;
    localparam int DEF_SYNC_DEPTH = 2;

    typedef enum logic {
        PORT_IDLE  = 1'b0,
        PORT_SHIFT = 1'b1
    } port_state_e;

    typedef enum logic [1:0] {
        SH_HOLD    = 2'd0,
        SH_LOAD    = 2'd1,
        SH_CLEAR   = 2'd2,
        SH_ADVANCE = 2'd3
    } shift_op_e;

    typedef struct packed {
        logic sel_fall;
        logic sel_rise;
        logic clk_fall;
    } port_events_t;

    // Select has precedence over the serial clock: a frame edge always wins.
    function automatic shift_op_e pick_op(port_events_t ev, port_state_e st);
        if (ev.sel_fall)                          return SH_LOAD;
        else if (ev.sel_rise)                     return SH_CLEAR;
        else if (ev.clk_fall && st == PORT_SHIFT) return SH_ADVANCE;
        else                                      return SH_HOLD;
    endfunction

endpackage

// File: rtl/ap_sync.sv
module ap_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_LVL;
                    else     chain[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_LVL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ap_edge.sv
module ap_edge #(
    parameter bit   RISING  = 1'b0,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic evt
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_LVL;
        else     prev <= lvl;
    end

    generate
        if (RISING) begin : g_rise
            assign evt = lvl & ~prev;
        end else begin : g_fall
            assign evt = ~lvl & prev;
        end
    endgenerate
endmodule

// File: rtl/ap_shift.sv
module ap_shift
    import angle_port_pkg::*;
#(
    parameter int WIDTH = DEF_ANGLE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  shift_op_e        op,
    input  logic [WIDTH-1:0] snap,
    output logic             bit_out,
    output logic [WIDTH-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            unique case (op)
                SH_LOAD:    word_q <= snap;
                SH_CLEAR:   word_q <= '0;
                SH_ADVANCE: word_q <= {word_q[WIDTH-2:0], 1'b0};
                default:    word_q <= word_q;
            endcase
        end
    end

    assign bit_out = word_q[WIDTH-1];
endmodule

// File: rtl/angle_readout_port.sv
module angle_readout_port
    import angle_port_pkg::*;
#(
    parameter int ANGLE_W     = DEF_ANGLE_W,
    parameter int SYNC_STAGES = DEF_SYNC_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ANGLE_W-1:0] angle_in,
    input  logic               cs_n,
    input  logic               sclk,
    output logic               sdo,
    output logic               sdo_en
);
    logic cs_s, sclk_s;
    logic cs_fall, cs_rise, sclk_fall;
    port_events_t ev;
    port_state_e  state;
    shift_op_e    op;
    logic [ANGLE_W-1:0] word_q;

    ap_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .d(cs_n), .q(cs_s));
    ap_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync_sclk (
        .clk(clk), .rst(rst), .d(sclk), .q(sclk_s));

    ap_edge #(.RISING(1'b0), .RST_LVL(1'b1)) u_cs_fall (
        .clk(clk), .rst(rst), .lvl(cs_s), .evt(cs_fall));
    ap_edge #(.RISING(1'b1), .RST_LVL(1'b1)) u_cs_rise (
        .clk(clk), .rst(rst), .lvl(cs_s), .evt(cs_rise));
    ap_edge #(.RISING(1'b0), .RST_LVL(1'b1)) u_sclk_fall (
        .clk(clk), .rst(rst), .lvl(sclk_s), .evt(sclk_fall));

    always_comb begin
        ev.sel_fall = cs_fall;
        ev.sel_rise = cs_rise;
        ev.clk_fall = sclk_fall;
        op          = pick_op(ev, state);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PORT_IDLE;
        end else begin
            unique case (op)
                SH_LOAD:  state <= PORT_SHIFT;
                SH_CLEAR: state <= PORT_IDLE;
                default:  state <= state;
            endcase
        end
    end

    ap_shift #(.WIDTH(ANGLE_W)) u_shift (
        .clk(clk), .rst(rst), .op(op), .snap(angle_in),
        .bit_out(sdo), .word_q(word_q));

    assign sdo_en = (state == PORT_SHIFT);
endmodule

// File: rtl/angle_port_checker.sv
module angle_port_checker #(
    parameter int ANGLE_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               sdo,
    input logic               sdo_en,
    input logic               cs_fall,
    input logic               cs_rise,
    input logic               sclk_fall,
    input logic [ANGLE_W-1:0] word
);
    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        !sdo_en |-> !sdo);

    assert_enable_on_select_R2: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> sdo_en);

    assert_msb_first_step_R3: assert property (@(posedge clk) disable iff (rst)
        (sdo_en && sclk_fall && !cs_rise && !cs_fall)
        |=> word == {$past(word[ANGLE_W-2:0]), 1'b0});

    assert_zero_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (sdo_en && word == '0 && !cs_rise && !cs_fall) |=> word == '0);

    assert_release_ends_R5: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> (!sdo_en && word == '0));

    assert_snapshot_held_R6: assert property (@(posedge clk) disable iff (rst)
        (sdo_en && !sclk_fall && !cs_rise && !cs_fall) |=> $stable(word));

    assert_idle_clock_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!sdo_en && !cs_fall) |=> (!sdo_en && word == '0));
endmodule

bind angle_readout_port angle_port_checker #(.ANGLE_W(ANGLE_W)) u_chk (
    .clk(clk), .rst(rst), .sdo(sdo), .sdo_en(sdo_en),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall),
    .word(word_q));

// File: tb/sim_angle_readout_port.sv
`timescale 1ns/1ps
module sim_angle_readout_port;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b1;
    logic [W-1:0] angle = '0;
    logic         sdo, sdo_en;

    always #2.5 clk = ~clk;

    angle_readout_port #(.ANGLE_W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .angle_in(angle), .cs_n(cs_n), .sclk(sclk),
        .sdo(sdo), .sdo_en(sdo_en));

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string phase  = "R8";

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: sample history queues, a frozen copy and a bit index.
    bit           cs_hist[$] = '{1'b1, 1'b1, 1'b1};
    bit           ck_hist[$] = '{1'b1, 1'b1, 1'b1};
    bit           m_en  = 0;
    logic [W-1:0] m_word = '0;
    int           m_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            cs_hist = '{1'b1, 1'b1, 1'b1};
            ck_hist = '{1'b1, 1'b1, 1'b1};
            m_en = 0; m_word = '0; m_cnt = 0;
        end else begin
            bit sel_fell, sel_rose, ck_fell;
            sel_fell = cs_hist[2] && !cs_hist[1];
            sel_rose = !cs_hist[2] && cs_hist[1];
            ck_fell  = ck_hist[2] && !ck_hist[1];
            if (sel_fell) begin
                m_en = 1; m_word = angle; m_cnt = 0;
            end else if (sel_rose) begin
                m_en = 0;
            end else if (m_en && ck_fell) begin
                m_cnt++;
            end
            cs_hist.push_front(cs_n); void'(cs_hist.pop_back());
            ck_hist.push_front(sclk); void'(ck_hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int exp_sdo;
            exp_sdo = (m_en && m_cnt < W) ? int'(m_word[W-1-m_cnt]) : 0;
            chk(phase, "enable vs model", int'(sdo_en), int'(m_en));
            chk(phase, "data vs model", int'(sdo), exp_sdo);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse();
        sclk = 1'b0; idle(6);
        sclk = 1'b1; idle(6);
    endtask

    task automatic do_read(logic [W-1:0] a, int nbits, bit disturb, string req);
        logic [W-1:0] got, exp;
        got = '0;
        angle = a;
        idle(1);
        cs_n = 1'b0;
        idle(2);
        chk("R2", "enable not yet up", int'(sdo_en), 0);
        idle(1);
        chk("R2", "enable after select", int'(sdo_en), 1);
        chk("R2", "MSB before first clock", int'(sdo), int'(a[W-1]));
        if (disturb) angle = ~a;
        idle(7);
        for (int i = 0; i < nbits; i++) begin
            if (i < W) got[W-1-i] = sdo;
            else chk("R4", "zero after last bit", int'(sdo), 0);
            sclk_pulse();
            if (disturb) angle = angle + 12'd37;
        end
        exp = a;
        for (int i = 0; i < W; i++) if (i >= nbits) exp[W-1-i] = 1'b0;
        chk(req, "assembled word", int'(got), int'(exp));
        cs_n = 1'b1;
        idle(4);
        chk("R5", "enable dropped after release", int'(sdo_en), 0);
        chk("R5", "data quiet after release", int'(sdo), 0);
        idle(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        chk("R8", "enable in reset", int'(sdo_en), 0);
        @(negedge clk); rst = 1'b0;
        idle(3);
        chk("R1", "idle enable", int'(sdo_en), 0);
        chk("R1", "idle data", int'(sdo), 0);

        phase = "R3";
        do_read(12'hA5C, 12, 1'b0, "R3");
        phase = "R7";
        do_read(12'h3C7, 12, 1'b0, "R7");
        phase = "R4";
        do_read(12'hFFF, 16, 1'b0, "R4");
        phase = "R5";
        do_read(12'hB6D, 5, 1'b0, "R5");
        phase = "R6";
        do_read(12'h6E1, 12, 1'b1, "R6");

        phase = "R9";
        for (int k = 0; k < 3; k++) sclk_pulse();
        chk("R9", "idle clocking leaves enable low", int'(sdo_en), 0);
        do_read(12'h801, 12, 1'b0, "R9");
        phase = "R7";
        do_read(12'h000, 13, 1'b0, "R7");

        phase = "R8";
        cs_n = 1'b0; idle(6);
        rst = 1'b1; idle(2);
        chk("R8", "reset during read disables", int'(sdo_en), 0);
        cs_n = 1'b1; idle(2);
        rst = 1'b0; idle(4);
        chk("R8", "idle after reset", int'(sdo_en), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule